// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This controller sits on the host side of a three-wire serial analog-to-digital converter. A host request produces an active-low conversion-start pulse. In auto-sleep mode the controller then waits a fixed wake-up interval. After that it watches the converter's busy line until it drops. Once busy is low, the controller emits exactly sixteen serial clock pulses and shifts in one data bit on each falling edge that it generates. The first four bits of each frame are expected to be zero. The last twelve bits, most significant bit first, form the conversion result.

The serial clock is derived from the system clock through a programmable half-period divider. An optional fixed idle gap after the eighth pulse splits the frame into two byte-sized bursts. A busy line that never falls is cut off by a programmable timeout, which returns the controller to idle and flags an error. After every read, a guard interval holds off the next conversion start. This keeps the required settling margin between the last clock edge of a read and the next start edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During and after reset, `convst_n_o` is high, `sclk_o` is low, `valid_o`, `zero_err_o` and `tmo_err_o` are low, and `ready_o` is high.
- R2: When `start_i` is high on a clock edge while `ready_o` is high, `convst_n_o` goes low in the next cycle and stays low for exactly PULSE_CYC cycles. `start_i` has no effect while `ready_o` is low.
- R3: Each read produces exactly sixteen `sclk_o` pulses. `sclk_o` is low in every cycle in which `convst_n_o` is low, and it stays low outside reads.
- R4: Every high phase and every ordinary low phase of `sclk_o` lasts `half_div_i` system clock cycles (1 or more). The first low phase begins on the edge where busy is seen low. A value of 4 or more keeps the serial clock at or below 12.5 MHz with a 100 MHz system clock.
- R5: `sdata_i` is sampled on each system clock edge where the controller drives `sclk_o` from high to low. The sixteen samples form a word, first sample in bit 15. In the cycle after the sixteenth falling edge, `valid_o` is high for exactly one cycle and `result_o` holds bits 11..0 of that word.
- R6: `zero_err_o` is high together with `valid_o` when any of bits 15..12 of the captured word is 1. It is low otherwise.
- R7: While waiting, if `busy_i` is sampled high on `busy_tmo_i` consecutive edges (`busy_tmo_i` of 1 or more), the controller returns to idle and pulses `tmo_err_o` for one cycle. In that case it produces no serial clock pulse and no `valid_o`.
- R8: If `auto_sleep_i` was high when the start was accepted, `busy_i` is ignored for WAKE_CYC cycles after the start pulse ends. With busy already low, the first `sclk_o` rise then follows the rise of `convst_n_o` by WAKE_CYC+1+`half_div_i` cycles, against 1+`half_div_i` cycles without auto-sleep.
- R9: After the eighth falling edge, `sclk_o` stays low for BYTE_GAP+`half_div_i` cycles before the ninth pulse.
- R10: `ready_o` returns GUARD_CYC cycles after the `valid_o` cycle. The next fall of `convst_n_o` therefore comes at least GUARD_CYC+1 cycles after the sixteenth falling edge of `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a conversion and read |
| auto_sleep_i | input | 1 | Apply the wake-up wait for this conversion |
| half_div_i | input | DIV_W | Serial clock half period in system cycles |
| busy_tmo_i | input | TMO_W | Busy timeout in system cycles |
| busy_i | input | 1 | Converter busy indication |
| sdata_i | input | 1 | Converter serial data |
| convst_n_o | output | 1 | Active-low conversion start |
| sclk_o | output | 1 | Serial clock to the converter |
| ready_o | output | 1 | Idle and able to accept a start |
| result_o | output | 12 | Last conversion result |
| valid_o | output | 1 | One-cycle result strobe |
| zero_err_o | output | 1 | A leading bit read as one |
| tmo_err_o | output | 1 | Busy timeout occurred |

## Verification
The checks assume that `half_div_i` and `busy_tmo_i` are nonzero and stay constant from an accepted start until the controller is ready again, and that `busy_i` settles before the start pulse ends. The bench's converter model raises busy on the start fall and drops it after a chosen delay. It resets its bit pointer on the same edge and presents the next frame bit on each serial clock rise. The stimulus changes the divider and timeout only while the controller is idle, and it uses half periods of 4 and 5.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV_W     = 8,
  parameter int TMO_W     = 16,
  parameter int PULSE_CYC = 4,
  parameter int WAKE_CYC  = 600,
  parameter int GUARD_CYC = 30,
  parameter int BYTE_GAP  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             auto_sleep_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [TMO_W-1:0] busy_tmo_i,
  input  logic             busy_i,
  input  logic             sdata_i,
  output logic             convst_n_o,
  output logic             sclk_o,
  output logic             ready_o,
  output logic [11:0]      result_o,
  output logic             valid_o,
  output logic             zero_err_o,
  output logic             tmo_err_o
);
  localparam int WT = TMO_W > DIV_W ? TMO_W : DIV_W;
  localparam int WK = $clog2((WAKE_CYC > GUARD_CYC ? WAKE_CYC : GUARD_CYC) + PULSE_CYC + 1);
  localparam int CW = WT > WK ? WT : WK;
  localparam int GW = $clog2(BYTE_GAP + 2);

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_WAKE, S_WAIT, S_READ, S_GUARD} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap_q;
  logic [3:0]    nbit;
  logic [15:0]   shreg;
  logic          sleep_q, sclk_q;

  wire        half_end = cnt == CW'(half_div_i) - CW'(1);
  wire [15:0] sh_nx    = {shreg[14:0], sdata_i};

  assign convst_n_o = st != S_PULSE;
  assign sclk_o     = sclk_q;
  assign ready_o    = st == S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      gap_q      <= '0;
      nbit       <= '0;
      shreg      <= '0;
      sleep_q    <= 1'b0;
      sclk_q     <= 1'b0;
      result_o   <= '0;
      valid_o    <= 1'b0;
      zero_err_o <= 1'b0;
      tmo_err_o  <= 1'b0;
    end else begin
      valid_o    <= 1'b0;
      zero_err_o <= 1'b0;
      tmo_err_o  <= 1'b0;
      case (st)
        S_IDLE:
          if (start_i) begin
            st      <= S_PULSE;
            cnt     <= '0;
            sleep_q <= auto_sleep_i;
          end
        S_PULSE:
          if (cnt == CW'(PULSE_CYC - 1)) begin
            cnt <= '0;
            st  <= sleep_q ? S_WAKE : S_WAIT;
          end else cnt <= cnt + 1'b1;
        S_WAKE:
          if (cnt == CW'(WAKE_CYC - 1)) begin
            cnt <= '0;
            st  <= S_WAIT;
          end else cnt <= cnt + 1'b1;
        S_WAIT:
          if (!busy_i) begin
            st     <= S_READ;
            cnt    <= '0;
            nbit   <= '0;
            gap_q  <= '0;
            sclk_q <= 1'b0;
          end else if (cnt == CW'(busy_tmo_i) - CW'(1)) begin
            st        <= S_IDLE;
            tmo_err_o <= 1'b1;
          end else cnt <= cnt + 1'b1;
        S_READ:
          if (gap_q != '0) gap_q <= gap_q - 1'b1;
          else if (half_end) begin
            cnt    <= '0;
            sclk_q <= !sclk_q;
            if (sclk_q) begin
              shreg <= sh_nx;
              nbit  <= nbit + 1'b1;
              if (nbit == 4'd15) begin
                st         <= S_GUARD;
                valid_o    <= 1'b1;
                result_o   <= sh_nx[11:0];
                zero_err_o <= |sh_nx[15:12];
              end else if (nbit == 4'd7) gap_q <= GW'(BYTE_GAP);
            end
          end else cnt <= cnt + 1'b1;
        S_GUARD:
          if (cnt == CW'(GUARD_CYC - 1)) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_seq_ctrl_chk #(
  parameter int GUARD_CYC = 30
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic convst_n_o,
  input logic sclk_o,
  input logic ready_o,
  input logic valid_o,
  input logic zero_err_o,
  input logic tmo_err_o
);
  int since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= GUARD_CYC + 1;
    else if (valid_o) since <= 0;
    else if (since <= GUARD_CYC) since <= since + 1;
  end

  // R2
  start_from_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> $past(ready_o) && $past(start_i));
  // R3
  sclk_low_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> !sclk_o);
  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R6
  zero_err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_err_o |-> valid_o);
  // R7
  tmo_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |-> ready_o && !valid_o);
  // R10
  guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> since >= GUARD_CYC);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.GUARD_CYC(GUARD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .convst_n_o(convst_n_o),
  .sclk_o(sclk_o), .ready_o(ready_o), .valid_o(valid_o),
  .zero_err_o(zero_err_o), .tmo_err_o(tmo_err_o)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int PULSE = 4, WAKE = 40, GUARD = 30, GAP = 5;

  logic clk = 0, rst_n = 0, start_i = 0, auto_sleep_i = 0, busy_i = 0, sdata_i = 0;
  logic [7:0]  half_div_i = 8'd4;
  logic [15:0] busy_tmo_i = 16'd500;
  logic convst_n_o, sclk_o, ready_o, valid_o, zero_err_o, tmo_err_o;
  logic [11:0] result_o;

  adc_seq_ctrl #(.DIV_W(8), .TMO_W(16), .PULSE_CYC(PULSE), .WAKE_CYC(WAKE),
                 .GUARD_CYC(GUARD), .BYTE_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_sleep_i(auto_sleep_i),
    .half_div_i(half_div_i), .busy_tmo_i(busy_tmo_i), .busy_i(busy_i), .sdata_i(sdata_i),
    .convst_n_o(convst_n_o), .sclk_o(sclk_o), .ready_o(ready_o), .result_o(result_o),
    .valid_o(valid_o), .zero_err_o(zero_err_o), .tmo_err_o(tmo_err_o));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [15:0] adc_word = 16'h0000;
  int busy_len = 30;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // converter model: busy and serial data
  int bleft = 0, ridx = 0;
  logic cv_prev = 1, sc_prev = 0;
  always @(negedge clk) begin
    if (cv_prev && !convst_n_o) begin
      busy_i = 1; bleft = busy_len; ridx = 0; sdata_i = 0;
    end else if (busy_i) begin
      if (bleft <= 0) busy_i = 0; else bleft--;
    end
    if (sclk_o && !sc_prev) begin
      sdata_i = adc_word[15 - (ridx % 16)];
      ridx++;
    end
    cv_prev = convst_n_o; sc_prev = sclk_o;
  end

  // cycle reference model
  int m_ph = 0, m_t = 0;
  bit m_sleep = 0, e_valid = 0, e_tmo = 0, e_zerr = 0;
  logic [11:0] e_res = 0;
  always @(posedge clk) begin
    int h;
    h = int'(half_div_i);
    if (!rst_n) begin
      m_ph <= 0; m_t <= 0; e_valid <= 0; e_tmo <= 0;
    end else begin
      e_valid <= 0; e_tmo <= 0;
      case (m_ph)
        0: if (start_i) begin m_ph <= 1; m_t <= 0; m_sleep <= auto_sleep_i; end
        1: if (m_t + 1 == PULSE) begin m_t <= 0; m_ph <= m_sleep ? 2 : 3; end else m_t <= m_t + 1;
        2: if (m_t + 1 == WAKE) begin m_t <= 0; m_ph <= 3; end else m_t <= m_t + 1;
        3: if (!busy_i) begin m_ph <= 4; m_t <= 0; end
           else if (m_t + 1 == int'(busy_tmo_i)) begin m_ph <= 0; m_t <= 0; e_tmo <= 1; end
           else m_t <= m_t + 1;
        4: if (m_t + 1 == 32*h + GAP) begin
             m_ph <= 5; m_t <= 0; e_valid <= 1;
             e_res <= adc_word[11:0]; e_zerr <= |adc_word[15:12];
           end else m_t <= m_t + 1;
        default: if (m_t + 1 == GUARD) begin m_ph <= 0; m_t <= 0; end else m_t <= m_t + 1;
      endcase
    end
  end

  function automatic bit sclk_ref(input int t, input int h);
    if (t < 16*h) return (t % (2*h)) >= h;
    if (t < 16*h + GAP) return 0;
    return ((t - GAP) % (2*h)) >= h;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit es;
      es = (m_ph == 4) ? sclk_ref(m_t, int'(half_div_i)) : 1'b0;
      chk(convst_n_o == (m_ph != 1), "R2 convst_n", convst_n_o, m_ph != 1);
      chk(sclk_o == es, "R4 sclk", sclk_o, es);
      chk(ready_o == (m_ph == 0), "R10 ready", ready_o, m_ph == 0);
      chk(valid_o == e_valid, "R5 valid", valid_o, e_valid);
      chk(tmo_err_o == e_tmo, "R7 tmo_err", tmo_err_o, e_tmo);
      if (e_valid) begin
        chk(result_o == e_res, "R5 result", result_o, e_res);
        chk(zero_err_o == e_zerr, "R6 zero_err", zero_err_o, e_zerr);
      end else chk(!zero_err_o, "R6 zero_err idle", zero_err_o, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      failures++;
      $display("FAIL watchdog R1 actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_read(input logic [15:0] w, input int h, input bit sl, input int bl, input bit chk_first);
    int rises, pulse_len, first, lowrun, hi1, cv_rise, falls, n;
    logic ps, pc;
    @(negedge clk);
    adc_word = w; half_div_i = 8'(h); auto_sleep_i = sl; busy_len = bl; start_i = 1;
    rises = 0; pulse_len = 0; first = -1; lowrun = 0; hi1 = 0; cv_rise = 0; falls = 0;
    ps = sclk_o; pc = convst_n_o;
    for (n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (!ready_o) start_i = 0;
      if (rises == 4) start_i = 1;
      if (rises == 5) start_i = 0;
      if (!convst_n_o) pulse_len++;
      if (!convst_n_o && pc) falls++;
      if (convst_n_o && !pc) cv_rise = n;
      if (sclk_o && !ps) begin
        if (rises == 0) first = n - cv_rise;
        rises++;
      end
      if (rises == 1 && sclk_o) hi1++;
      if (rises == 8 && !sclk_o) lowrun++;
      ps = sclk_o; pc = convst_n_o;
      if (valid_o) break;
    end
    start_i = 0;
    chk(valid_o == 1, "R5 valid seen", valid_o, 1);
    chk(result_o == w[11:0], "R5 result", result_o, w[11:0]);
    chk(zero_err_o == (|w[15:12]), "R6 leading bits", zero_err_o, |w[15:12]);
    chk(rises == 16, "R3 pulse count", rises, 16);
    chk(pulse_len == PULSE, "R2 start width", pulse_len, PULSE);
    chk(falls == 1, "R2 start ignored while busy", falls, 1);
    chk(hi1 == h, "R4 high phase", hi1, h);
    chk(lowrun == GAP + h, "R9 byte gap", lowrun, GAP + h);
    if (chk_first)
      chk(first == (sl ? WAKE : 0) + 1 + h, "R8 wake delay", first, (sl ? WAKE : 0) + 1 + h);
    while (!ready_o) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(convst_n_o == 1, "R1 convst_n", convst_n_o, 1);
    chk(sclk_o == 0, "R1 sclk", sclk_o, 0);
    chk(ready_o == 1 && valid_o == 0, "R1 ready/valid", ready_o, 1);
    chk(zero_err_o == 0 && tmo_err_o == 0, "R1 errors", tmo_err_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(convst_n_o == 1 && sclk_o == 0, "R1 after reset", sclk_o, 0);

    run_read(16'h0ABC, 4, 0, 30, 0);
    run_read(16'h0FFF, 5, 0, 30, 0);
    run_read(16'h0000, 4, 0, 2, 1);
    run_read(16'h0123, 4, 1, 2, 1);
    run_read(16'h8123, 5, 0, 30, 0);
    run_read(16'h1001, 4, 1, 60, 0);

    // R10: start held high through a read, next start after the guard
    begin
      int k;
      @(negedge clk);
      adc_word = 16'h0555; busy_len = 20; half_div_i = 8'd4; auto_sleep_i = 0; start_i = 1;
      while (!valid_o) @(negedge clk);
      k = 0;
      while (convst_n_o && k < 500) begin @(negedge clk); k++; end
      chk(k == GUARD + 1, "R10 guard spacing", k, GUARD + 1);
      start_i = 0;
      while (!valid_o) @(negedge clk);
      chk(result_o == 12'h555, "R10 back-to-back result", result_o, 12'h555);
      while (!ready_o) @(negedge clk);
    end

    // R7: busy stuck high
    begin
      int k;
      bit seen_sclk;
      @(negedge clk);
      busy_len = 100000; busy_tmo_i = 16'd20; start_i = 1;
      k = 0; seen_sclk = 0;
      while (!tmo_err_o && k < 2000) begin
        @(negedge clk); k++;
        if (!ready_o) start_i = 0;
        if (sclk_o) seen_sclk = 1;
      end
      chk(tmo_err_o == 1, "R7 timeout flagged", tmo_err_o, 1);
      chk(ready_o == 1, "R7 back to idle", ready_o, 1);
      chk(seen_sclk == 0, "R7 no serial clock", seen_sclk, 0);
      @(negedge clk);
      chk(tmo_err_o == 0, "R7 one-cycle flag", tmo_err_o, 0);
      busy_len = 30; busy_tmo_i = 16'd500;
      repeat (150) @(negedge clk);
    end

    run_read(16'h0F0F, 4, 0, 30, 0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule